// File: doc/BRIEF.md
# Raster Line Interrupt Unit

This block watches the current raster line number supplied by an external timing generator and raises an interrupt when the line reaches one of four programmable target lines. Each of the four sources fires at most once per frame. A frame-start strobe re-arms all of them.

Each source has a sticky status bit. The status bit is set whether or not the source is enabled, so software can inspect pending events and discard stale ones before it unmasks a source. Status bits are cleared only through a dedicated write-one-to-clear register. A mask register selects which pending bits drive the single interrupt output.

A typical setup gives one source target line 0 as a vertical-blank event. Another source targets a line close to 90% of the last display line, to wake a context loader before the active area ends.

All registers are 32 bits wide. They sit on a simple single-cycle register bus:
- A write happens on the clock edge while `bus_we` is high.
- Read data is a combinational function of `bus_addr`.

Top module: `line_irq_unit`

## Requirements
- R1: After reset, the following all read as zero and the interrupt output is low:
  - the status register (0x5C),
  - the mask register (0x68),
  - all four target registers.
- R2: The target registers are at byte addresses 0x50, 0x54, 0x6C and 0x70, for sources 0 to 3. Each holds its target line in bits 28:16. A read returns the stored line in bits 28:16, and every other bit reads as zero.
- R3: Status bit i (bit i of 0x5C) sets on the clock edge that ends the first cycle in which the line input equals the target of source i. That cycle may be the frame-start cycle itself, or any later cycle of the same frame. The source then does not fire again until the next frame-start strobe.
- R4: A status bit stays set until it is cleared. A status bit never sets without a line match.
- R5: Writing a 1 to bit i of the clear register (0x60) clears status bit i on that edge. Writing 0 leaves status bit i unchanged. The clear register always reads as zero.
- R6: If a line match and a clear of the same status bit fall in the same cycle, the status bit ends up set.
- R7: A status bit sets on its line match even while its mask bit is 0. A masked pending bit does not raise the interrupt.
- R8: The interrupt output is high exactly when some bit is set in both the status register and the mask register. The mask register is at 0x68, bits 3:0, and bit i enables source i.
- R9: A write to an address outside the map changes no register, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_line | input | LINE_W | Current raster line number |
| frame_start | input | 1 | One-cycle strobe at the start of a frame; re-arms all sources |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt: any pending status bit that is unmasked |

## Verification
The assertions take one thing for granted: `frame_start` marks the start of each frame, and the line input moves forward through the frame. Each line is held for one or more cycles.

The bench keeps to this. It drives every frame from line 0, with the strobe in the first cycle, and holds each line for two cycles.

Targets that are not under test are parked beyond the last line of the frame, so they never fire. Every target line in the small frame is swept for each source, with the status word checked after every cycle.

Cycles are also replayed without a strobe, to show that no source fires twice in one frame.

// File: rtl/line_irq_unit.sv
module line_irq_unit #(
  parameter int LINE_W = 13,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] cur_line,
  input  logic              frame_start,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int NSRC      = 4;
  localparam int FIELD_LSB = 16;
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(32'h5C);
  localparam logic [ADDR_W-1:0] ADDR_CLR  = ADDR_W'(32'h60);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(32'h68);

  function automatic logic [ADDR_W-1:0] line_addr(input int idx);
    return (idx < 2) ? ADDR_W'(32'h50 + 4 * idx) : ADDR_W'(32'h6C + 4 * (idx - 2));
  endfunction

  logic [NSRC-1:0][LINE_W-1:0] tgt;
  logic [NSRC-1:0] armed, match, hit, status, mask, clr;

  always_comb begin
    for (int i = 0; i < NSRC; i++) match[i] = (cur_line == tgt[i]);
  end

  assign hit = (armed | {NSRC{frame_start}}) & match;
  assign clr = (bus_we && bus_addr == ADDR_CLR) ? bus_wdata[NSRC-1:0] : '0;
  assign irq = |(status & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt    <= '0;
      armed  <= '0;
      status <= '0;
      mask   <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++)
        if (bus_we && bus_addr == line_addr(i)) tgt[i] <= bus_wdata[FIELD_LSB +: LINE_W];
      if (bus_we && bus_addr == ADDR_MASK) mask <= bus_wdata[NSRC-1:0];
      armed  <= (armed | {NSRC{frame_start}}) & ~match;
      status <= (status & ~clr) | hit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NSRC; i++)
      if (bus_addr == line_addr(i)) bus_rdata[FIELD_LSB +: LINE_W] = tgt[i];
    if (bus_addr == ADDR_STAT) bus_rdata[NSRC-1:0] = status;
    if (bus_addr == ADDR_MASK) bus_rdata[NSRC-1:0] = mask;
  end
endmodule

module line_irq_unit_chk #(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_start,
  input logic [NSRC-1:0] hit,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] clr,
  input logic            irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> status[i]);
    p_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> (frame_start || !hit[i]));
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !clr[i]) |=> status[i]);
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[i] && !hit[i]) |=> !status[i]);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !hit[i]) |=> !status[i]);
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && hit[i]) |=> status[i]);
  end
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
  p_pending_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & mask) != '0) |-> irq);
endmodule

bind line_irq_unit line_irq_unit_chk #(.NSRC(4)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .hit(hit),
  .status(status), .mask(mask), .clr(clr), .irq(irq));

// File: tb/line_irq_unit_tb.sv
module line_irq_unit_tb_top;
  localparam int LINE_W = 13;
  localparam int ADDR_W = 8;
  localparam int FR     = 12;
  localparam logic [LINE_W-1:0] PARK = '1;

  logic clk = 0, rst_n = 0, frame_start = 0, bus_we = 0, irq;
  logic [LINE_W-1:0] cur_line = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  line_irq_unit #(.LINE_W(LINE_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cur_line(cur_line), .frame_start(frame_start),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [ADDR_W-1:0] laddr(input int i);
    return (i < 2) ? ADDR_W'(32'h50 + 4 * i) : ADDR_W'(32'h6C + 4 * (i - 2));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cyc(input logic [LINE_W-1:0] ln, input logic fs);
    cur_line = ln; frame_start = fs;
    @(negedge clk);
    frame_start = 0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h5C, v); check("R1 status", v, 0);
    rd(8'h68, v); check("R1 mask", v, 0);
    for (int i = 0; i < 4; i++) begin rd(laddr(i), v); check("R1 target", v, 0); end
    check("R1 irq", {31'd0, irq}, 0);
    for (int i = 0; i < 4; i++) wr(laddr(i), 32'(PARK) << 16);

    // R2 / R3 sweep: every source, every target line in the frame plus one beyond
    for (int i = 0; i < 4; i++) begin
      for (int t = 0; t <= FR; t++) begin
        wr(laddr(i), 32'hE000_FFFF | (32'(t) << 16));
        rd(laddr(i), v); check("R2 readback", v, 32'(t) << 16);
        wr(8'h60, 32'hF);
        bus_addr = 8'h5C;
        for (int l = 0; l < FR; l++)
          for (int k = 0; k < 2; k++) begin
            cyc(LINE_W'(l), (l == 0 && k == 0));
            #1; check("R3 sweep", bus_rdata, (t < FR && l >= t) ? (32'd1 << i) : 0);
          end
        wr(8'h60, 32'hF);
        bus_addr = 8'h5C;
        for (int l = 0; l < FR; l++) begin
          cyc(LINE_W'(l), 0);
          #1; check("R3 no refire", bus_rdata, 0);
        end
      end
      wr(laddr(i), 32'(PARK) << 16);
    end

    // R4 / R7: all targets at line 0, masks off
    for (int i = 0; i < 4; i++) wr(laddr(i), 0);
    cyc('0, 1);
    cyc(LINE_W'(3), 0); cyc(LINE_W'(5), 0);
    rd(8'h5C, v); check("R4 sticky", v, 32'hF);
    check("R7 masked no irq", {31'd0, irq}, 0);
    // R5 clear semantics
    wr(8'h60, 0);
    rd(8'h5C, v); check("R5 zero write", v, 32'hF);
    wr(8'h60, 32'h5);
    rd(8'h5C, v); check("R5 clear", v, 32'hA);
    rd(8'h60, v); check("R5 clr reads 0", v, 0);
    // R9 unmapped
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h64, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R9 unmapped read", v, 0);
    rd(8'h5C, v); check("R9 status intact", v, 32'hA);
    rd(8'h68, v); check("R9 mask intact", v, 0);
    // R8 mask
    wr(8'h68, 32'h4);
    rd(8'h68, v); check("R8 mask read", v, 32'h4);
    check("R8 masked off pending", {31'd0, irq}, 0);
    wr(8'h68, 32'h2);
    check("R8 irq high", {31'd0, irq}, 1);
    wr(8'h60, 32'h2);
    check("R8 irq low after clear", {31'd0, irq}, 0);
    // R6 set wins: source 0 target 7, match with strobe and clear together
    wr(8'h60, 32'hF);
    wr(laddr(0), 32'd7 << 16);
    cur_line = 7; frame_start = 1; bus_we = 1; bus_addr = 8'h60; bus_wdata = 32'h1;
    @(negedge clk);
    frame_start = 0; bus_we = 0;
    rd(8'h5C, v); check("R6 set wins", v[0], 1);
    wr(8'h68, 32'h1);
    check("R8 irq from source0", {31'd0, irq}, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule